// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block holds the run-control state for a multi-channel DMA engine: a start bit, a pause bit and a cancel bit for each channel, plus one global enable and a software reset. The host reaches it through a plain word-addressed write port with a combinational read port. Every control bit has a write-enable bit next to it in an upper byte lane. A write changes only the bits whose write-enable is set, so software can start, pause or cancel one channel with a single store and no read-modify-write.

The channel engines return three per-channel status pulses or levels: transfer complete, cancel finished, and engine idle. From these the block clears control bits on its own. A completed transfer drops the start bit. A finished cancel drops the cancel and start bits. A channel that stops also loses its pause bit.

The global enable is a soft request. When it is cleared, the running status stays high until no channel holds its start bit and every engine reports idle. The software reset runs for a fixed number of cycles, reads back as busy during that time, and leaves every control bit at zero.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After rst_n is low, ch_enable, ch_suspend, ch_abort and ctrl_running are 0, and words 0, 1 and 2 read as 0.
- R2: A write to word 1 changes the start bit of channel n (bit n) only when bit n+8 of the same write is 1. Other channels are left as they were.
- R3: Word 1 reads start bits at bit n and pause bits at bit n+16. Word 2 reads cancel bits at bit n. Word 0 reads the global enable at bit 0, reset-busy at bit 1 and running status at bit 2. All write-enable positions read as 0.
- R4: A transfer-complete pulse on channel n clears its start bit at the next edge. This wins over a write that sets the bit in the same cycle.
- R5: A write to word 1 changes the pause bit of channel n (bit n+16) only when bit n+24 of the same write is 1.
- R6: When a channel's start bit falls, its pause bit is 0 from that same edge.
- R7: A write to word 2 sets the cancel bit of channel n (bit n) when bit n+8 is 1. The bit holds until a cancel-finished pulse, which clears both the cancel bit and the start bit of that channel at the next edge.
- R8: While a channel's cancel bit is set, writes cannot set its pause or start bit. A single write that sets both pause and start of a stopped channel sets the pause bit and leaves start at 0.
- R9: The global enable is word 0 bit 0, with its write-enable at bit 8. ctrl_running is registered from the previous cycle: it is 1 when the global enable is set, or any start bit is set, or any ch_idle input is 0.
- R10: Writing 1 to word 0 bit 1 with bit 9 set starts a software reset. Reset-busy reads 1 for exactly 4 cycles, and every channel bit and the global enable are 0 from the first edge after the reset starts. Writes to words 0, 1 and 2 are ignored while reset is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe, one word per cycle |
| host_addr | input | ADDR_W | Word index for both write and read |
| host_wdata | input | 32 | Write data with write-enable lanes |
| host_rdata | output | 32 | Combinational read data of the addressed word |
| ch_xfer_done | input | NUM_CH | Per-channel transfer-complete pulse |
| ch_idle | input | NUM_CH | Per-channel engine fully stopped |
| ch_abort_done | input | NUM_CH | Per-channel cancel-finished pulse |
| ch_enable | output | NUM_CH | Start level to each channel engine |
| ch_suspend | output | NUM_CH | Pause level to each channel engine |
| ch_abort | output | NUM_CH | Cancel level to each channel engine |
| ctrl_running | output | 1 | Controller still active |

## Verification
Some behaviours are checked on every cycle for every channel. The assertions cover these:
- a start bit never moves without its write-enable lane or a hardware event;
- a completion or cancel-finished pulse always clears its bit one edge later;
- a pause bit never outlives its start bit;
- a pending cancel keeps the pause bit from rising;
- every channel bit is zero while reset is busy;
- the running status follows any active enable.

Other behaviours only the bench scenarios can show:
- the exact readback layout, including write-enable lanes reading as zero;
- the four-cycle length of the reset-busy window;
- the delayed drop of the running status after the global enable is cleared while an engine is still busy;
- the same-write conflict in which a pause request blocks a start request.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   localparam int WORD_W      = 32;
   localparam int LANE_W      = 8;
   localparam int MAX_CH      = LANE_W;
   // word indices
   localparam int WORD_GLOBAL = 0;
   localparam int WORD_CHAN   = 1;
   localparam int WORD_ABORT  = 2;
   // channel word lanes
   localparam int EN_LSB      = 0;
   localparam int EN_WE_LSB   = 8;
   localparam int SUS_LSB     = 16;
   localparam int SUS_WE_LSB  = 24;
   // abort word lanes
   localparam int AB_LSB      = 0;
   localparam int AB_WE_LSB   = 8;
   // global word bits
   localparam int G_EN_BIT    = 0;
   localparam int G_RST_BIT   = 1;
   localparam int G_RUN_BIT   = 2;
   localparam int G_WE_OFF    = 8;
endpackage

// File: rtl/dcc_chan_slice.sv
module dcc_chan_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic wr_chan,
   input  logic wr_abort,
   input  logic en_d,
   input  logic en_we,
   input  logic sus_d,
   input  logic sus_we,
   input  logic ab_d,
   input  logic ab_we,
   input  logic xfer_done,
   input  logic abort_done,
   output logic en_q,
   output logic sus_q,
   output logic ab_q
);
   logic en_n, sus_n, ab_n, sus_set;

   always_comb begin
      // cancel: software write, hardware completion wins
      ab_n = ab_q;
      if (wr_abort && ab_we) ab_n = ab_d;
      if (abort_done)        ab_n = 1'b0;

      // a pause request in the same write blocks a start request
      sus_set = wr_chan && sus_we && sus_d;

      en_n = en_q;
      if (wr_chan && en_we) begin
         if (!en_d)                    en_n = 1'b0;
         else if (!sus_set && !ab_q)   en_n = 1'b1;
      end
      if (xfer_done || abort_done) en_n = 1'b0;

      sus_n = sus_q;
      if (wr_chan && sus_we) sus_n = sus_d && !ab_q;
      if (en_q && !en_n)     sus_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sus_q <= 1'b0;
         ab_q  <= 1'b0;
      end else if (clr) begin
         en_q  <= 1'b0;
         sus_q <= 1'b0;
         ab_q  <= 1'b0;
      end else begin
         en_q  <= en_n;
         sus_q <= sus_n;
         ab_q  <= ab_n;
      end
   end
endmodule

// File: rtl/dcc_reset_seq.sv
module dcc_reset_seq #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("dcc_reset_seq: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
      else if (start)        cnt_q <= CW'(CYCLES);
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/dcc_global.sv
module dcc_global (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic wr_en_bit,
   input  logic en_d,
   input  logic any_active,
   output logic ctrl_en_q,
   output logic running_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en_q <= 1'b0;
         running_q <= 1'b0;
      end else begin
         if (clr)            ctrl_en_q <= 1'b0;
         else if (wr_en_bit) ctrl_en_q <= en_d;
         running_q <= ctrl_en_q | any_active;
      end
   end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
   parameter int NUM_CH     = 8,
   parameter int RST_CYCLES = 4,
   parameter int ADDR_W     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_wr,
   input  logic [ADDR_W-1:0]          host_addr,
   input  logic [dcc_pkg::WORD_W-1:0] host_wdata,
   output logic [dcc_pkg::WORD_W-1:0] host_rdata,
   input  logic [NUM_CH-1:0]          ch_xfer_done,
   input  logic [NUM_CH-1:0]          ch_idle,
   input  logic [NUM_CH-1:0]          ch_abort_done,
   output logic [NUM_CH-1:0]          ch_enable,
   output logic [NUM_CH-1:0]          ch_suspend,
   output logic [NUM_CH-1:0]          ch_abort,
   output logic                       ctrl_running
);
   import dcc_pkg::*;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("dma_chan_ctrl: NUM_CH must be 1..8");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("dma_chan_ctrl: ADDR_W must be at least 2");
   end

   logic rst_busy;
   logic ctrl_en_q;
   logic hit_glb, hit_chan, hit_abort;
   logic wr_glb, wr_chan, wr_abort;
   logic any_active;

   assign hit_glb   = (host_addr == ADDR_W'(WORD_GLOBAL));
   assign hit_chan  = (host_addr == ADDR_W'(WORD_CHAN));
   assign hit_abort = (host_addr == ADDR_W'(WORD_ABORT));

   assign wr_glb   = host_wr && hit_glb   && !rst_busy;
   assign wr_chan  = host_wr && hit_chan  && !rst_busy;
   assign wr_abort = host_wr && hit_abort && !rst_busy;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      dcc_chan_slice u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (rst_busy),
         .wr_chan    (wr_chan),
         .wr_abort   (wr_abort),
         .en_d       (host_wdata[EN_LSB + n]),
         .en_we      (host_wdata[EN_WE_LSB + n]),
         .sus_d      (host_wdata[SUS_LSB + n]),
         .sus_we     (host_wdata[SUS_WE_LSB + n]),
         .ab_d       (host_wdata[AB_LSB + n]),
         .ab_we      (host_wdata[AB_WE_LSB + n]),
         .xfer_done  (ch_xfer_done[n]),
         .abort_done (ch_abort_done[n]),
         .en_q       (ch_enable[n]),
         .sus_q      (ch_suspend[n]),
         .ab_q       (ch_abort[n])
      );
   end

   dcc_reset_seq #(.CYCLES(RST_CYCLES)) u_rst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_glb && host_wdata[G_RST_BIT + G_WE_OFF] && host_wdata[G_RST_BIT]),
      .busy  (rst_busy)
   );

   assign any_active = (|ch_enable) | ~(&ch_idle);

   dcc_global u_glb (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (rst_busy),
      .wr_en_bit  (wr_glb && host_wdata[G_EN_BIT + G_WE_OFF]),
      .en_d       (host_wdata[G_EN_BIT]),
      .any_active (any_active),
      .ctrl_en_q  (ctrl_en_q),
      .running_q  (ctrl_running)
   );

   logic [WORD_W-1:0] rd_glb, rd_chan, rd_abort;

   always_comb begin
      rd_glb = '0;
      rd_glb[G_EN_BIT]  = ctrl_en_q;
      rd_glb[G_RST_BIT] = rst_busy;
      rd_glb[G_RUN_BIT] = ctrl_running;

      rd_chan = '0;
      rd_chan[EN_LSB  +: NUM_CH] = ch_enable;
      rd_chan[SUS_LSB +: NUM_CH] = ch_suspend;

      rd_abort = '0;
      rd_abort[AB_LSB +: NUM_CH] = ch_abort;

      if (hit_glb)        host_rdata = rd_glb;
      else if (hit_chan)  host_rdata = rd_chan;
      else if (hit_abort) host_rdata = rd_abort;
      else                host_rdata = '0;
   end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       host_wr,
   input logic [ADDR_W-1:0]          host_addr,
   input logic [dcc_pkg::WORD_W-1:0] host_wdata,
   input logic [NUM_CH-1:0]          ch_xfer_done,
   input logic [NUM_CH-1:0]          ch_abort_done,
   input logic [NUM_CH-1:0]          ch_enable,
   input logic [NUM_CH-1:0]          ch_suspend,
   input logic [NUM_CH-1:0]          ch_abort,
   input logic                       ctrl_running,
   input logic                       rst_busy,
   input logic                       ctrl_en_q
);
   import dcc_pkg::*;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      p_we_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!(host_wr && host_addr == ADDR_W'(WORD_CHAN) && host_wdata[EN_WE_LSB + n])
          && !ch_xfer_done[n] && !ch_abort_done[n] && !rst_busy)
         |=> $stable(ch_enable[n]));

      p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ch_xfer_done[n] |=> !ch_enable[n]);

      p_pause_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ch_enable[n]) |-> !ch_suspend[n]);

      p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ch_abort_done[n] |=> (!ch_abort[n] && !ch_enable[n]));

      p_abort_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_abort[n] && !ch_suspend[n]) |=> !ch_suspend[n]);
   end

   p_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en_q || (|ch_enable)) |=> ctrl_running);

   p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_busy |=> (ch_enable == '0 && ch_suspend == '0 && ch_abort == '0 && !ctrl_en_q));
endmodule

bind dma_chan_ctrl dcc_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_chan_ctrl_bench.sv
module dma_chan_ctrl_bench;
   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_wr = 1'b0;
   logic [1:0]    host_addr = '0;
   logic [31:0]   host_wdata = '0;
   logic [31:0]   host_rdata;
   logic [N-1:0]  ch_xfer_done = '0;
   logic [N-1:0]  ch_idle = '1;
   logic [N-1:0]  ch_abort_done = '0;
   logic [N-1:0]  ch_enable, ch_suspend, ch_abort;
   logic          ctrl_running;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_chan_ctrl #(.NUM_CH(N), .RST_CYCLES(4), .ADDR_W(2)) u_dma_chan_ctrl (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the capturing edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   function automatic logic [31:0] cw(input int n, input bit en, input bit en_we,
                                      input bit sus, input bit sus_we);
      logic [31:0] w = '0;
      w[n] = en; w[n+8] = en_we; w[n+16] = sus; w[n+24] = sus_we;
      return w;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      logic [7:0]  exp_en;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 enable", {24'd0, ch_enable}, 0);
      chk("R1 suspend", {24'd0, ch_suspend}, 0);
      chk("R1 abort", {24'd0, ch_abort}, 0);
      chk("R1 running", {31'd0, ctrl_running}, 0);
      for (int a = 0; a < 3; a++) begin
         rd(2'(a), r); chk("R1 readback", r, 0);
      end

      // R2 start bits: sweep channels, masked writes
      exp_en = '0;
      for (int n = 0; n < N; n++) begin
         wr(2'd1, cw(n, 1, 1, 0, 0));
         exp_en[n] = 1'b1;
         chk("R2 set one channel", {24'd0, ch_enable}, {24'd0, exp_en});
      end
      wr(2'd1, 32'h0000_0000);
      chk("R2 no we keeps", {24'd0, ch_enable}, 32'hFF);
      // R3 readback, write-enable lanes read zero
      rd(2'd1, r); chk("R3 chan word", r, 32'h0000_00FF);
      for (int n = 0; n < N; n += 2) begin
         wr(2'd1, cw(n, 0, 1, 0, 0));
         exp_en[n] = 1'b0;
      end
      chk("R2 clear even", {24'd0, ch_enable}, {24'd0, exp_en});

      // R4 completion clears enable, wins over same-cycle write
      ch_xfer_done[3] = 1'b1;
      wr(2'd1, cw(1, 1, 1, 0, 0) | cw(3, 1, 1, 0, 0));
      ch_xfer_done = '0;
      chk("R4 done clears", {31'd0, ch_enable[3]}, 0);
      wr(2'd1, cw(0, 1, 1, 0, 0));
      ch_xfer_done[0] = 1'b1;
      @(negedge clk);
      ch_xfer_done = '0;
      chk("R4 done clear ch0", {31'd0, ch_enable[0]}, 0);

      // R5 pause masked write
      wr(2'd1, cw(5, 0, 0, 1, 1));
      chk("R5 pause set", {31'd0, ch_suspend[5]}, 1);
      wr(2'd1, cw(5, 0, 0, 0, 0));
      chk("R5 no we keeps", {31'd0, ch_suspend[5]}, 1);
      rd(2'd1, r); chk("R3 pause lane", r[23:16], 8'h20);
      // R6 pause drops with enable
      ch_xfer_done[5] = 1'b1;
      @(negedge clk);
      ch_xfer_done = '0;
      chk("R6 enable gone", {31'd0, ch_enable[5]}, 0);
      chk("R6 pause gone", {31'd0, ch_suspend[5]}, 0);

      // R7 cancel, hold, finish
      wr(2'd1, cw(6, 1, 1, 0, 0));
      wr(2'd2, 32'h0000_4040);
      chk("R7 cancel set", {24'd0, ch_abort}, 32'h40);
      rd(2'd2, r); chk("R3 cancel word", r, 32'h40);
      repeat (3) @(negedge clk);
      chk("R7 cancel holds", {31'd0, ch_abort[6]}, 1);
      ch_abort_done[6] = 1'b1;
      @(negedge clk);
      ch_abort_done = '0;
      chk("R7 cancel clears", {31'd0, ch_abort[6]}, 0);
      chk("R7 enable clears", {31'd0, ch_enable[6]}, 0);

      // R8 priorities
      wr(2'd1, cw(4, 1, 1, 1, 1));
      chk("R8 pause set", {31'd0, ch_suspend[4]}, 1);
      chk("R8 start blocked", {31'd0, ch_enable[4]}, 0);
      wr(2'd1, cw(4, 0, 0, 0, 1));
      wr(2'd2, 32'h0000_0404);
      wr(2'd1, cw(2, 0, 0, 1, 1));
      chk("R8 cancel blocks pause", {31'd0, ch_suspend[2]}, 0);
      wr(2'd1, cw(2, 1, 1, 0, 0));
      chk("R8 cancel blocks start", {31'd0, ch_enable[2]}, 0);
      ch_abort_done[2] = 1'b1;
      @(negedge clk);
      ch_abort_done = '0;

      // clear all starts
      wr(2'd1, 32'h0000_FF00);
      chk("R2 all clear", {24'd0, ch_enable}, 0);

      // R9 global enable and running status
      @(negedge clk);
      chk("R9 idle not running", {31'd0, ctrl_running}, 0);
      wr(2'd0, 32'h0000_0101);
      @(negedge clk);
      chk("R9 running", {31'd0, ctrl_running}, 1);
      rd(2'd0, r); chk("R3 global word", r, 32'h5);
      ch_idle[2] = 1'b0;
      wr(2'd0, 32'h0000_0100);
      repeat (3) @(negedge clk);
      chk("R9 busy engine keeps running", {31'd0, ctrl_running}, 1);
      ch_idle = '1;
      @(negedge clk);
      chk("R9 running drops", {31'd0, ctrl_running}, 0);
      wr(2'd1, cw(7, 1, 1, 0, 0));
      @(negedge clk);
      chk("R9 enabled channel runs", {31'd0, ctrl_running}, 1);

      // R10 software reset
      wr(2'd2, 32'h0000_0101);
      wr(2'd0, 32'h0000_0101);
      wr(2'd0, 32'h0000_0202);
      rd(2'd0, r); chk("R10 busy after write", {31'd0, r[1]}, 1);
      wr(2'd1, cw(1, 1, 1, 0, 0));
      chk("R10 channels cleared", {8'd0, ch_abort, ch_suspend, ch_enable}, 0);
      rd(2'd0, r); chk("R10 global cleared", {31'd0, r[0]}, 0);
      @(negedge clk);
      rd(2'd0, r); chk("R10 busy cycle 3", {31'd0, r[1]}, 1);
      @(negedge clk);
      rd(2'd0, r); chk("R10 busy cycle 4", {31'd0, r[1]}, 1);
      @(negedge clk);
      rd(2'd0, r); chk("R10 busy ends", {31'd0, r[1]}, 0);
      chk("R10 write ignored", {31'd0, ch_enable[1]}, 0);
      wr(2'd1, cw(1, 1, 1, 0, 0));
      chk("R10 writes accepted after", {31'd0, ch_enable[1]}, 1);

      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule